// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog timer. It counts ticks of a slow clock enable and reaches a timeout when a period chosen by a 4-bit prescaler has passed without a kick. A timeout can raise an interrupt request, pulse a system reset, or do both in turn. In the combined mode the first timeout raises the interrupt and hardware clears the interrupt enable at the same time. Software must then set the enable again before the next period ends, or that next timeout pulses the reset.

The reset enable and the prescaler are protected. To change them, software first writes the control register with both the change bit and the reset-enable bit set. This opens a window of four clock cycles. One more write inside the window may then clear the reset enable or load a new prescaler. A sticky cause flag records that the watchdog has pulsed the reset. While the flag is set, the reset enable is held at one.

The register interface is a plain synchronous write strobe with an 8-bit data bus and a one-bit select, plus a combinational readback. No data streams through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `wdog_timer`

## Requirements
- R1: After reset, rd_data reads 0x00 and irq, sys_rst and rst_cause are low.
- R2: Prescaler value n (rd_data/wr_data bits [3:0]) gives a timeout after 2^(BASE_LOG2+n) counted ticks from the last clear, for n from 0 to 9. Values 10 to 15 give the same period as 9.
- R3: The count advances only in cycles where tick_en is high. A kick or a timeout clears the count to zero, and a kick in the same cycle as the final tick prevents the timeout.
- R4: With interrupt enable (bit 6) set and reset enable (bit 4) clear, a timeout sets irq. irq stays high until irq_ack is sampled high, and sys_rst stays low.
- R5: With bits 6 and 4 both set, a timeout sets irq and clears bit 6 on the same edge. The following timeout then pulses sys_rst, unless software has set bit 6 again first.
- R6: With bit 6 clear and bit 4 set, a timeout pulses sys_rst high for exactly one cycle and sets rst_cause on the same edge.
- R7: rst_cause stays set until a write with wr_sel=1 and wr_data[0]=0. While it is set, bit 4 reads 1 and cannot be cleared, even through the unlock window.
- R8: A control write (wr_sel=0) with bits 5 and 4 both set opens the change window. rd_data bit 5 reads 1 while the window is open. A control write in the next 4 cycles loads bit 4 and bits [3:0] freely and closes the window. The window also closes by itself after 4 cycles.
- R9: Outside the window, a control write updates bit 6, can set bit 4 but not clear it, and leaves bits [3:0] unchanged.
- R10: With bits 6 and 4 both clear, the timer never times out. No irq and no sys_rst occur however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick enable; the count advances in each cycle where this is high |
| kick | input | 1 | Clears the count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the cause-flag register |
| wr_data | input | 8 | Write data: [6] irq enable, [5] change, [4] reset enable, [3:0] prescaler; for wr_sel=1, [0]=0 clears the flag |
| irq_ack | input | 1 | Clears a pending interrupt request |
| rd_data | output | 8 | Readback: [7] irq, [6] irq enable, [5] window open, [4] reset enable, [3:0] prescaler |
| irq | output | 1 | Interrupt request level |
| sys_rst | output | 1 | Single-cycle system reset pulse |
| rst_cause | output | 1 | Sticky flag: the watchdog has pulsed the reset |

## Verification
Writes show on rd_data one edge after the strobe. A timeout shows on irq, sys_rst and rst_cause at the edge that counts the final tick, and the hardware clear of bit 6 shows at that same edge. The change window accepts writes at the four edges that follow the unlock edge. A behavioural reference model steps at every rising edge, and every output is compared 1 ns later, so each result is checked in the cycle it is due. Targeted checks measure the number of edges from a kick or a write to irq or sys_rst, and compare each count against 2^(BASE_LOG2+n).

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PS_W    = 4;
  localparam int PS_MAX  = 9;
  localparam int WIN_CYC = 4;
  // control bit positions, shared by write data and readback
  localparam int CB_IRQ  = 7;
  localparam int CB_IE   = 6;
  localparam int CB_CE   = 5;
  localparam int CB_RE   = 4;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_RST  = 2'b10,
    MODE_BOTH = 2'b11
  } mode_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int WIN = WIN_CYC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic [6:0]      wr_data,
  input  logic            hw_ie_clr,
  input  logic            cause,
  output logic            ie,
  output logic            re,
  output logic [PS_W-1:0] ps,
  output logic            win_open
);
  localparam int WW = $clog2(WIN + 1);

  logic [WW-1:0]   win_q;
  logic            ie_q, re_q;
  logic [PS_W-1:0] ps_q;
  logic            unlock;

  assign unlock   = wr_data[CB_CE] & wr_data[CB_RE];
  assign win_open = (win_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      ie_q  <= 1'b0;
      re_q  <= 1'b0;
      ps_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ie_q <= wr_data[CB_IE];
        if (win_open) begin
          re_q <= wr_data[CB_RE];
          ps_q <= wr_data[PS_W-1:0];
        end else if (wr_data[CB_RE]) begin
          re_q <= 1'b1;
        end
        win_q <= unlock ? WW'(WIN) : '0;
      end else if (win_open) begin
        win_q <= win_q - 1'b1;
      end
      if (hw_ie_clr) ie_q <= 1'b0;
      if (cause)     re_q <= 1'b1;
    end
  end

  assign ie = ie_q;
  assign re = re_q;
  assign ps = ps_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick_en,
  input  logic            kick,
  input  logic [PS_W-1:0] ps,
  output logic            expire
);
  localparam int CW = BASE_LOG2 + PS_MAX;

  logic [CW-1:0]     cnt_q;
  logic [PS_MAX:0]   hit;
  logic [PS_W-1:0]   ps_sat;

  assign ps_sat = (ps > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : ps;

  for (genvar g = 0; g <= PS_MAX; g++) begin : g_hit
    localparam logic [CW:0] LAST = (CW+1)'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    assign hit[g] = ({1'b0, cnt_q} == LAST);
  end

  assign expire = active & tick_en & ~kick & hit[ps_sat];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || kick || expire) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ie,
  input  logic re,
  input  logic irq_ack,
  input  logic flag_clr,
  output logic hw_ie_clr,
  output logic irq,
  output logic sys_rst,
  output logic cause
);
  mode_e mode;
  logic  fire_irq, fire_rst;

  assign mode      = mode_e'({re, ie});
  assign fire_irq  = expire & (mode == MODE_IRQ || mode == MODE_BOTH);
  assign fire_rst  = expire & (mode == MODE_RST);
  assign hw_ie_clr = expire & (mode == MODE_BOTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      sys_rst <= 1'b0;
      cause   <= 1'b0;
    end else begin
      if (fire_irq)     irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      sys_rst <= fire_rst;
      if (fire_rst)      cause <= 1'b1;
      else if (flag_clr) cause <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       kick,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       irq_ack,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sys_rst,
  output logic       rst_cause
);
  logic            ie, re, win_open, expire, hw_ie_clr;
  logic [PS_W-1:0] ps;
  logic            unused_wr7;

  assign unused_wr7 = wr_data[7];

  wdog_regs #(.WIN(WIN_CYC)) u_regs (
    .clk, .rst_n,
    .wr_ctrl  (wr_en & ~wr_sel),
    .wr_data  (wr_data[6:0]),
    .hw_ie_clr,
    .cause    (rst_cause),
    .ie, .re, .ps, .win_open
  );

  wdog_count #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk, .rst_n,
    .active  (ie | re),
    .tick_en, .kick, .ps,
    .expire
  );

  wdog_event u_event (
    .clk, .rst_n, .expire, .ie, .re, .irq_ack,
    .flag_clr (wr_en & wr_sel & ~wr_data[0]),
    .hw_ie_clr,
    .irq, .sys_rst,
    .cause    (rst_cause)
  );

  assign rd_data = {irq, ie, win_open, re, ps};
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       irq_ack,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       sys_rst,
  input logic       rst_cause
);
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R4
  AST_IE_DROPS_IN_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(rd_data[4])) |-> !rd_data[6]); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst); // R6
  AST_RST_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> rst_cause); // R6
  AST_RST_NEEDS_RE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(rd_data[4])); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cause && !(wr_en && wr_sel && !wr_data[0])) |=> rst_cause); // R7
  AST_CAUSE_HOLDS_RE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cause |-> rd_data[4]); // R7
  AST_WIN_FROM_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[5]) |-> $past(wr_en && !wr_sel && wr_data[5] && wr_data[4])); // R8
endmodule

bind wdog_timer wdog_chk u_chk (
  .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .irq_ack,
  .rd_data, .irq, .sys_rst, .rst_cause
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  localparam int BL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1, kick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, sys_rst, rst_cause;

  int checks = 0, fails = 0;
  bit tick_alt = 0;
  bit wd_hit = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.BASE_LOG2(BL)) u_dut (
    .clk, .rst_n, .tick_en, .kick, .wr_en, .wr_sel, .wr_data, .irq_ack,
    .rd_data, .irq, .sys_rst, .rst_cause
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_win = 0, m_ps = 0;
  bit m_ie = 0, m_re = 0, m_irq = 0, m_rst = 0, m_flag = 0;

  always @(posedge clk) begin
    bit on, exp_t, n_ie, n_re, n_flag;
    int n_ps, n_win, lim;
    if (!rst_n) begin
      m_cnt = 0; m_win = 0; m_ps = 0; m_ie = 0; m_re = 0;
      m_irq = 0; m_rst = 0; m_flag = 0;
    end else begin
      lim   = 1 << (BL + ((m_ps > 9) ? 9 : m_ps));
      on    = m_ie | m_re;
      exp_t = on && tick_en && !kick && (m_cnt == lim - 1);
      n_ie = m_ie; n_re = m_re; n_ps = m_ps;
      n_win = (m_win > 0) ? m_win - 1 : 0;
      if (wr_en && !wr_sel) begin
        n_ie = wr_data[6];
        if (m_win > 0) begin n_re = wr_data[4]; n_ps = wr_data[3:0]; end
        else if (wr_data[4]) n_re = 1;
        n_win = (wr_data[5] && wr_data[4]) ? 4 : 0;
      end
      if (exp_t && m_ie && m_re) n_ie = 0;
      if (m_flag) n_re = 1;
      if (exp_t && m_ie) m_irq = 1; else if (irq_ack) m_irq = 0;
      m_rst  = exp_t && !m_ie && m_re;
      n_flag = m_flag;
      if (m_rst) n_flag = 1; else if (wr_en && wr_sel && !wr_data[0]) n_flag = 0;
      if (!on || kick || exp_t) m_cnt = 0; else if (tick_en) m_cnt++;
      m_ie = n_ie; m_re = n_re; m_ps = n_ps; m_win = n_win; m_flag = n_flag;
    end
    #1;
    if (rst_n) begin
      chk("R4 model irq", irq, m_irq);
      chk("R6 model sys_rst", sys_rst, m_rst);
      chk("R7 model rst_cause", rst_cause, m_flag);
      chk("R8 model rd_data", rd_data, {m_irq, m_ie, m_win != 0, m_re, 4'(m_ps)});
    end
  end

  always @(negedge clk) if (tick_alt) tick_en <= ~tick_en; else tick_en <= 1'b1;

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_sel = 0; wr_data = 8'h00;
  endtask
  task automatic pulse_kick();
    @(negedge clk); kick = 1; @(negedge clk); kick = 0;
  endtask
  task automatic ack();
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask
  task automatic wait_irq(int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin @(posedge clk); #1; n++; end
  endtask
  task automatic wait_rst(int lim, output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!sys_rst && n < lim);
  endtask

  task automatic run_all();
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 sys_rst", sys_rst, 0); chk("R1 cause", rst_cause, 0);
    rst_n = 1;
    // R10: disabled timer never fires
    seen = 0;
    repeat (300) begin @(negedge clk); seen |= irq | sys_rst; end
    chk("R10 no event while off", seen, 0);
    // R4 / R2: irq mode, ps 0
    wr(0, 8'h40); wait_irq(100, n);
    chk("R2 ps0 period", n, 16);
    repeat (5) @(negedge clk);
    chk("R4 irq held", irq, 1); chk("R4 no reset", rst_cause, 0);
    ack(); chk("R4 irq cleared by ack", irq, 0);
    // R3: kicks prevent timeout
    pulse_kick(); seen = 0;
    repeat (10) begin repeat (8) @(negedge clk); seen |= irq; pulse_kick(); end
    chk("R3 kicks hold off", seen, 0);
    // R3: gated ticks double the period
    tick_alt = 1; pulse_kick(); wait_irq(100, n);
    chk("R3 gated ticks", (n >= 30 && n <= 33), 1);
    tick_alt = 0; ack();
    // R8: unlock then change
    wr(0, 8'h70); chk("R8 window open", rd_data[5], 1);
    wr(0, 8'h41); chk("R8 protected write", rd_data[6:0], 7'h41);
    // R9: outside window
    wr(0, 8'h43); chk("R9 ps ignored", rd_data[3:0], 1);
    chk("R9 re still clear", rd_data[4], 0);
    // R8: window expires after 4 cycles
    wr(0, 8'h70); repeat (5) @(negedge clk);
    chk("R8 window closed", rd_data[5], 0);
    wr(0, 8'h45); chk("R8 late ps ignored", rd_data[3:0], 1);
    chk("R8 late re kept", rd_data[4], 1);
    // R5: combined mode, ps 0
    pulse_kick(); ack();
    wr(0, 8'h70); wr(0, 8'h50); wait_irq(200, n);
    chk("R5 irq in combined", irq, 1);
    chk("R5 ie cleared by hw", rd_data[6], 0);
    wait_rst(100, n);
    chk("R5 second timeout resets", sys_rst, 1);
    chk("R6 reset after one period", n, 16);
    chk("R6 cause set", rst_cause, 1);
    @(posedge clk); #1; chk("R6 pulse one cycle", sys_rst, 0);
    // R7: flag locks re
    wr(0, 8'h30); wr(0, 8'h00);
    chk("R7 re held by cause", rd_data[4], 1);
    wr(1, 8'h00); chk("R7 cause cleared", rst_cause, 0);
    wr(0, 8'h30); wr(0, 8'h00);
    chk("R7 re clears after flag", rd_data, 8'h80);
    ack(); chk("R1 idle again", rd_data, 8'h00);
    // R5: software re-arms, no reset
    wr(0, 8'h70); wr(0, 8'h50); seen = 0;
    repeat (3) begin
      wait_irq(200, n); wr(0, 8'h50); ack();
    end
    repeat (10) begin @(negedge clk); seen |= sys_rst; end
    chk("R5 rearm avoids reset", seen | rst_cause, 0);
    // R2: reserved value 12 acts as 9
    pulse_kick(); wr(0, 8'h70); wr(0, 8'h4C); ack(); pulse_kick();
    wait_irq(20000, n);
    chk("R2 ps12 period", n, 16 * 512);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd_hit = 1; end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule